// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block sits on the outbound request path of a PCI Express style controller. It holds a small bank of programmable translation regions. Each region is written through a simple word-write port with a 64-bit base, an inclusive 32-bit limit, a 64-bit target, a type field and an enable bit. An internal-platform request address that falls inside an enabled memory region leaves the block with the region's base replaced by its target, and the offset inside the window is kept.

Every result says whether the outgoing address needs a 64-bit memory packet, which is the case when the address is above 4G, or fits a 32-bit one. A request that hits no region passes through unchanged and is marked as a miss. The request-to-result path has one registered stage with valid/ready flow control on both sides.

Top module: `ob_xlate_win`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and every region is disabled, so a request returns as a miss.
- R2: A configuration write is a single cycle with `cfg_wr`=1. It sets the register chosen by `cfg_sel` in region `cfg_idx`, using these codes: 0 for the type (low `TYPE_W` bits), 1 for the enable (bit 31), 2 for the base low, 3 for the base high, 4 for the limit, 5 for the target low and 6 for the target high.
- R3: A region matches when three things hold: the request's bits 63:32 equal its base high, the request's bits 31:0 lie between base low and limit with both ends included, and the region is enabled and of type 0.
- R4: A matched request returns `rsp_addr` = {target high, target low} + (request[31:0] − base low), with `rsp_hit`=1 and `rsp_region` set to the region index.
- R5: `rsp_wide` is 1 exactly when bits 63:32 of `rsp_addr` are nonzero.
- R6: A region whose enable bit 31 is 0, or whose type is nonzero, never matches.
- R7: When several regions match, the one with the lowest index wins.
- R8: A request that matches no region returns `rsp_addr` equal to the request address, with `rsp_hit`=0 and `rsp_region`=0.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. Each accepted request gives exactly one result, in order, one cycle after acceptance. While `rsp_valid`=1 and `rsp_ready`=0, the result outputs stay stable.
- R10: A configuration write in the same cycle as an accepted request does not affect that request. It does apply to requests accepted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NREG) | Region index to write |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when valid |
| req_addr | input | 64 | Untranslated request address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | $clog2(NREG) | Index of the matching region |
| rsp_wide | output | 1 | 64-bit packet needed |

## Verification
The bench sends addresses at both ends of a window and one past each end, so an off-by-one in the inclusive compare or in the lower bound shows up as a wrong hit flag. It also sends an address whose low word is inside the window but whose high word differs, which separates a 32-bit compare from a full 64-bit one. A second window that overlaps the first shows whether priority works, and after the first window is disabled the same address shows the enable control taking effect. A third window with a target near 4G is hit at offsets that land on 0xFFFFFFFF and on 0x1_00000000, which covers the packet-size flag and the carry into the upper word. Further cases cover a nonzero type, a stalled consumer, and a configuration write that arrives in the same cycle as a request.

// File: rtl/ob_xlate_win.sv
module ob_xlate_win #(
  parameter int NREG   = 4,
  parameter int TYPE_W = 5,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [IW-1:0] cfg_idx,
  input  logic [2:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [63:0]   req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [63:0]   rsp_addr,
  output logic          rsp_hit,
  output logic [IW-1:0] rsp_region,
  output logic          rsp_wide
);

  logic [31:0]       base_lo [NREG];
  logic [31:0]       base_hi [NREG];
  logic [31:0]       limit   [NREG];
  logic [31:0]       tgt_lo  [NREG];
  logic [31:0]       tgt_hi  [NREG];
  logic [TYPE_W-1:0] rtype   [NREG];
  logic              enab    [NREG];

  logic [NREG-1:0]   match;
  logic [IW-1:0]     sel;
  logic [31:0]       offs;
  logic [63:0]       xaddr;
  logic [63:0]       nxt;
  logic              fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_lo[i] <= '0;
        base_hi[i] <= '0;
        limit[i]   <= '0;
        tgt_lo[i]  <= '0;
        tgt_hi[i]  <= '0;
        rtype[i]   <= '0;
        enab[i]    <= 1'b0;
      end
    end else if (cfg_wr) begin
      case (cfg_sel)
        3'd0: rtype[cfg_idx]   <= cfg_wdata[TYPE_W-1:0];
        3'd1: enab[cfg_idx]    <= cfg_wdata[31];
        3'd2: base_lo[cfg_idx] <= cfg_wdata;
        3'd3: base_hi[cfg_idx] <= cfg_wdata;
        3'd4: limit[cfg_idx]   <= cfg_wdata;
        3'd5: tgt_lo[cfg_idx]  <= cfg_wdata;
        3'd6: tgt_hi[cfg_idx]  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = enab[g] && (rtype[g] == '0) &&
                      (req_addr[63:32] == base_hi[g]) &&
                      (req_addr[31:0] >= base_lo[g]) &&
                      (req_addr[31:0] <= limit[g]);
  end

  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  assign offs  = req_addr[31:0] - base_lo[sel];
  assign xaddr = {tgt_hi[sel], tgt_lo[sel]} + {32'h0, offs};
  assign nxt   = (|match) ? xaddr : req_addr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_wide   <= 1'b0;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_addr   <= nxt;
      rsp_hit    <= |match;
      rsp_region <= sel;
      rsp_wide   <= |nxt[63:32];
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

endmodule

module ob_xlate_win_chk #(
  parameter int NREG = 4,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [63:0]   req_addr,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [63:0]   rsp_addr,
  input logic          rsp_hit,
  input logic [IW-1:0] rsp_region,
  input logic          rsp_wide
);

  AST_WIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_wide == (rsp_addr[63:32] != 32'h0))); // R5

  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid && (rsp_hit || rsp_addr == $past(req_addr)))); // R8

  AST_MISS_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_region == '0)); // R8

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_hit) &&
                                   $stable(rsp_region) && $stable(rsp_wide))); // R9

endmodule

bind ob_xlate_win ob_xlate_win_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/ob_xlate_win_test.sv
module ob_xlate_win_test;
  localparam int CLK = 10;
  localparam int Q   = CLK / 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [1:0]  cfg_idx = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [63:0] req_addr = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [63:0] rsp_addr;
  logic        rsp_hit;
  logic [1:0]  rsp_region;
  logic        rsp_wide;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [67:0] exp_q[$];
  string       tag_q[$];

  ob_xlate_win uut (.*);

  always #(CLK/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wcfg(input logic [1:0] idx, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = idx; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] e, input logic eh,
                      input logic [1:0] er, input string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    #(Q);
    while (!req_ready) begin
      @(negedge clk);
      #(Q);
    end
    exp_q.push_back({e, eh, er, |e[63:32]});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(Q);
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected result", {rsp_addr, rsp_hit, rsp_region, rsp_wide}, '0);
        end else begin
          logic [67:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_addr, rsp_hit, rsp_region, rsp_wide} == e, t,
                {rsp_addr, rsp_hit, rsp_region, rsp_wide}, e);
        end
      end
    end
  end

  initial begin
    #(CLK * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #(Q);
    check(!rsp_valid && req_ready, "R1 reset state", {66'h0, rsp_valid, req_ready}, 68'h1);
    send(64'h0001_0000, 64'h0001_0000, 0, 0, "R1 unprogrammed miss");

    wcfg(0, 3'd2, 32'h0001_0000);
    wcfg(0, 3'd3, 32'h0);
    wcfg(0, 3'd4, 32'h0005_FFFF);
    wcfg(0, 3'd5, 32'h2000_0000);
    wcfg(0, 3'd6, 32'h1000_0000);
    wcfg(0, 3'd0, 32'h0);
    send(64'h0001_0000, 64'h0001_0000, 0, 0, "R6 not yet enabled");
    wcfg(0, 3'd1, 32'h8000_0000);

    send(64'h0001_0000, 64'h1000_0000_2000_0000, 1, 0, "R4 base edge R5 wide");
    send(64'h0005_FFFF, 64'h1000_0000_2004_FFFF, 1, 0, "R3 limit inclusive");
    send(64'h0006_0000, 64'h0006_0000, 0, 0, "R3 past limit R8");
    send(64'h0000_FFFF, 64'h0000_FFFF, 0, 0, "R3 below base R8");
    send(64'h1_0001_0000, 64'h1_0001_0000, 0, 0, "R3 upper mismatch R5 wide pass");
    send(64'h0002_0010, 64'h1000_0000_2001_0010, 1, 0, "R2 cfg takes effect");

    wcfg(1, 3'd2, 32'h0002_0000);
    wcfg(1, 3'd4, 32'h0002_FFFF);
    wcfg(1, 3'd5, 32'h8000_0000);
    wcfg(1, 3'd1, 32'h8000_0000);
    send(64'h0002_0010, 64'h1000_0000_2001_0010, 1, 0, "R7 lowest wins");
    wcfg(0, 3'd1, 32'h7FFF_FFFF);
    send(64'h0002_0010, 64'h0000_0000_8000_0010, 1, 1, "R6 disable R7 next region R5 narrow");

    wcfg(2, 3'd2, 32'h0040_0000);
    wcfg(2, 3'd4, 32'h004F_FFFF);
    wcfg(2, 3'd5, 32'hFFFF_F000);
    wcfg(2, 3'd0, 32'h1);
    wcfg(2, 3'd1, 32'h8000_0000);
    send(64'h0040_0004, 64'h0040_0004, 0, 0, "R6 nonzero type");
    wcfg(2, 3'd0, 32'h0);
    send(64'h0040_0FFF, 64'h0000_0000_FFFF_FFFF, 1, 2, "R5 just under 4G");
    send(64'h0040_1000, 64'h0000_0001_0000_0000, 1, 2, "R5 carry into upper");

    @(negedge clk);
    rsp_ready = 0;
    send(64'h0002_0020, 64'h0000_0000_8000_0020, 1, 1, "R9 stalled item A");
    fork
      send(64'h0040_0010, 64'h0000_0000_FFFF_F010, 1, 2, "R9 stalled item B");
      begin
        repeat (2) @(negedge clk);
        #(Q);
        check(!req_ready && rsp_valid, "R9 ready low while stalled",
              {66'h0, req_ready, rsp_valid}, 68'h1);
        @(negedge clk);
        rsp_ready = 1;
      end
    join

    wcfg(0, 3'd1, 32'h8000_0000);
    repeat (3) @(negedge clk);
    cfg_wr = 1; cfg_idx = 0; cfg_sel = 3'd1; cfg_wdata = 32'h0;
    req_valid = 1; req_addr = 64'h0001_0000;
    #(Q);
    check(req_ready, "R10 ready for same-cycle case", {67'h0, req_ready}, 68'h1);
    exp_q.push_back({64'h1000_0000_2000_0000, 1'b1, 2'd0, 1'b1});
    tag_q.push_back("R10 same-cycle write ignored");
    @(negedge clk);
    cfg_wr = 0; req_valid = 0;
    send(64'h0001_0000, 64'h0001_0000, 0, 0, "R10 write applies next");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results returned", 68'(exp_q.size()), 68'h0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule